// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block gives each of NCPU processors two doorbell interrupts: a "remote" kind, which any processor can ring on any set of processors, and a "local" kind, normally rung by a processor on itself. Each processor has its own register access port. The processor's index is fixed by the port it uses. Through that port it sees a local view of its own interrupt state. It also sees explicit per-processor views through which it can set, clear, mask or unmask the doorbells of any processor.

A processor learns which doorbell fired by reading its event register. The read returns a typed code and masks the delivered kind at once. Software acknowledges the kind to drop its pending flag, then unmasks it to accept the next one. A per-processor input from the neighbouring hardware-interrupt logic holds off doorbell events while a higher-ranked hardware event is waiting. Each processor also has one interrupt line, which is high while any of its doorbells is pending and unmasked.

Top module: `ipiUnit`

## Requirements
- R1: After reset, every doorbell is not pending and is masked: all ipiIrq lines are low and an event read returns 0.
- R2: A read of local offset 0x2000 returns the index of the port that issued it.
- R3: A write to local offset 0x2008 with data bit c set makes the remote doorbell of processor c pending. Processors whose bit is clear are unaffected.
- R4: A read of local offset 0x2004 with the remote doorbell pending and unmasked returns 0x00040001 (type 4 in bits 23:16, number 1 in bits 15:0) and masks the remote doorbell of the reader.
- R5: Masking on delivery keeps the pending flag. A write of bit 0 to local mask-clear (0x2028) raises the line again. A write of bit 0 to local ack (0x200c) clears the pending flag.
- R6: The local doorbell is delivered with code 0x00040002, and bit 31 selects it in every set, clear, ack and mask register.
- R7: When both doorbells are pending and unmasked, successive event reads return the remote code, then the local code, then 0.
- R8: While hwBusy of a processor is high, its event read returns 0 and leaves its pending and mask state unchanged.
- R9: Per-processor views at 0x5000 + (cpu << 7) act on that processor: +0x08 sets pending, +0x0c clears pending, +0x24 sets the mask, +0x28 clears the mask. Bit 0 selects remote and bit 31 selects local.
- R10: If a send to a processor and a clear of the same doorbell land in the same cycle, the doorbell ends up pending.
- R11: In the ack and mask registers, data bits 1 to 30 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accReq | input | NCPU | Access request per processor port |
| accWe | input | NCPU | Write enable per port (0 means read) |
| accAddr | input | NCPU*16 | Byte address per port |
| accWdata | input | NCPU*32 | Write data per port |
| hwBusy | input | NCPU | A hardware interrupt event ranks above doorbells for this processor |
| accRvalid | output | NCPU | Read data valid, one cycle after a read request |
| accRdata | output | NCPU*32 | Read data per port |
| ipiIrq | output | NCPU | Doorbell interrupt line per processor |

## Verification
The bench sends with sparse bit patterns such as 0101, so that a doorbell landing on the wrong processor shows up on a line that should stay low. It rings one doorbell kind alone and then both together. Single rings show whether each code and auto-mask is tied to the right kind; both together show whether the reporting order is right. Writes that use only data bits 1 to 30 separate correct bit selection from decoding the whole word. A same-cycle send and ack from two ports separates set-wins from clear-wins. Event reads under hwBusy check that the hold-off has no side effects.

// File: rtl/ipiPkg.sv
package ipiPkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SELF_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFF_WHO     = 16'h2000;
  localparam logic [ADDR_W-1:0] OFF_EVENT   = 16'h2004;
  localparam logic [ADDR_W-1:0] OFF_SEND    = 16'h2008;
  localparam logic [ADDR_W-1:0] OFF_ACK     = 16'h200c;
  localparam logic [ADDR_W-1:0] OFF_MSKSET  = 16'h2024;
  localparam logic [ADDR_W-1:0] OFF_MSKCLR  = 16'h2028;

  localparam logic [3:0] VIEW_PAGE = 4'h5;
  localparam logic [6:0] VIEW_SET    = 7'h08;
  localparam logic [6:0] VIEW_CLR    = 7'h0c;
  localparam logic [6:0] VIEW_MSKSET = 7'h24;
  localparam logic [6:0] VIEW_MSKCLR = 7'h28;

  localparam logic [DATA_W-1:0] EVT_REMOTE = 32'h0004_0001;
  localparam logic [DATA_W-1:0] EVT_LOCAL  = 32'h0004_0002;

  typedef enum logic [1:0] {SEL_NONE, SEL_WHO, SEL_EVT} rdSelT;

  typedef struct packed {
    logic setRemote;
    logic setLocal;
    logic clrRemote;
    logic clrLocal;
    logic mskSetRemote;
    logic mskSetLocal;
    logic mskClrRemote;
    logic mskClrLocal;
    logic evtRead;
  } ipiCmdT;
endpackage

// File: rtl/ipiCtrl.sv
module ipiCtrl
  import ipiPkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [NCPU-1:0]        accReq,
  input  logic [NCPU-1:0]        accWe,
  input  logic [NCPU*ADDR_W-1:0] accAddr,
  input  logic [NCPU*DATA_W-1:0] accWdata,
  output ipiCmdT                 cmd [NCPU],
  output rdSelT                  rdSel [NCPU],
  output logic [NCPU-1:0]        rdEn
);
  logic [ADDR_W-1:0] addrP [NCPU];
  logic [DATA_W-1:0] dataP [NCPU];
  logic [NCPU-1:0]   viewHit;
  logic [NCPU-1:0]   wrP;

  for (genvar p = 0; p < NCPU; p++) begin : gSlice
    assign addrP[p]   = accAddr[p*ADDR_W +: ADDR_W];
    assign dataP[p]   = accWdata[p*DATA_W +: DATA_W];
    assign viewHit[p] = (addrP[p][15:12] == VIEW_PAGE) &&
                        ({1'b0, addrP[p][11:7]} < 6'(NCPU));
    assign wrP[p]     = accReq[p] && accWe[p];
    assign rdEn[p]    = accReq[p] && !accWe[p];
  end

  always_comb begin
    for (int t = 0; t < NCPU; t++) begin
      cmd[t] = '0;
    end
    for (int p = 0; p < NCPU; p++) begin
      rdSel[p] = SEL_NONE;
      if (wrP[p]) begin
        unique case (addrP[p])
          OFF_SEND: begin
            for (int t = 0; t < NCPU; t++) begin
              cmd[t].setRemote = cmd[t].setRemote | dataP[p][t];
            end
          end
          OFF_ACK: begin
            cmd[p].clrRemote = cmd[p].clrRemote | dataP[p][0];
            cmd[p].clrLocal  = cmd[p].clrLocal  | dataP[p][SELF_BIT];
          end
          OFF_MSKSET: begin
            cmd[p].mskSetRemote = cmd[p].mskSetRemote | dataP[p][0];
            cmd[p].mskSetLocal  = cmd[p].mskSetLocal  | dataP[p][SELF_BIT];
          end
          OFF_MSKCLR: begin
            cmd[p].mskClrRemote = cmd[p].mskClrRemote | dataP[p][0];
            cmd[p].mskClrLocal  = cmd[p].mskClrLocal  | dataP[p][SELF_BIT];
          end
          default: ;
        endcase
        if (viewHit[p]) begin
          for (int t = 0; t < NCPU; t++) begin
            if (addrP[p][11:7] == 5'(t)) begin
              unique case (addrP[p][6:0])
                VIEW_SET: begin
                  cmd[t].setRemote = cmd[t].setRemote | dataP[p][0];
                  cmd[t].setLocal  = cmd[t].setLocal  | dataP[p][SELF_BIT];
                end
                VIEW_CLR: begin
                  cmd[t].clrRemote = cmd[t].clrRemote | dataP[p][0];
                  cmd[t].clrLocal  = cmd[t].clrLocal  | dataP[p][SELF_BIT];
                end
                VIEW_MSKSET: begin
                  cmd[t].mskSetRemote = cmd[t].mskSetRemote | dataP[p][0];
                  cmd[t].mskSetLocal  = cmd[t].mskSetLocal  | dataP[p][SELF_BIT];
                end
                VIEW_MSKCLR: begin
                  cmd[t].mskClrRemote = cmd[t].mskClrRemote | dataP[p][0];
                  cmd[t].mskClrLocal  = cmd[t].mskClrLocal  | dataP[p][SELF_BIT];
                end
                default: ;
              endcase
            end
          end
        end
      end
      if (rdEn[p]) begin
        if (addrP[p] == OFF_WHO) begin
          rdSel[p] = SEL_WHO;
        end else if (addrP[p] == OFF_EVENT) begin
          rdSel[p] = SEL_EVT;
          cmd[p].evtRead = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ipiDatapath.sv
module ipiDatapath
  import ipiPkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ipiCmdT                 cmd [NCPU],
  input  rdSelT                  rdSel [NCPU],
  input  logic [NCPU-1:0]        rdEn,
  input  logic [NCPU-1:0]        hwBusy,
  output logic [NCPU-1:0]        accRvalid,
  output logic [NCPU*DATA_W-1:0] accRdata,
  output logic [NCPU-1:0]        ipiIrq,
  output logic [NCPU-1:0]        pendRemote,
  output logic [NCPU-1:0]        pendLocal,
  output logic [NCPU-1:0]        mskRemote,
  output logic [NCPU-1:0]        mskLocal
);
  logic [NCPU-1:0] readyRemote, readyLocal, dlvRemote, dlvLocal;

  assign readyRemote = pendRemote & ~mskRemote;
  assign readyLocal  = pendLocal  & ~mskLocal;
  assign ipiIrq      = readyRemote | readyLocal;

  for (genvar t = 0; t < NCPU; t++) begin : gDeliver
    assign dlvRemote[t] = cmd[t].evtRead && !hwBusy[t] && readyRemote[t];
    assign dlvLocal[t]  = cmd[t].evtRead && !hwBusy[t] && !readyRemote[t] && readyLocal[t];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendRemote <= '0;
      pendLocal  <= '0;
      mskRemote  <= '1;
      mskLocal   <= '1;
      accRvalid  <= '0;
      accRdata   <= '0;
    end else begin
      for (int t = 0; t < NCPU; t++) begin
        if (cmd[t].setRemote)      pendRemote[t] <= 1'b1;
        else if (cmd[t].clrRemote) pendRemote[t] <= 1'b0;
        if (cmd[t].setLocal)       pendLocal[t]  <= 1'b1;
        else if (cmd[t].clrLocal)  pendLocal[t]  <= 1'b0;
        if (cmd[t].mskSetRemote || dlvRemote[t]) mskRemote[t] <= 1'b1;
        else if (cmd[t].mskClrRemote)            mskRemote[t] <= 1'b0;
        if (cmd[t].mskSetLocal || dlvLocal[t])   mskLocal[t]  <= 1'b1;
        else if (cmd[t].mskClrLocal)             mskLocal[t]  <= 1'b0;
        accRvalid[t] <= rdEn[t];
        unique case (rdSel[t])
          SEL_WHO: accRdata[t*DATA_W +: DATA_W] <= DATA_W'(t);
          SEL_EVT: accRdata[t*DATA_W +: DATA_W] <= dlvRemote[t] ? EVT_REMOTE :
                                                  dlvLocal[t]  ? EVT_LOCAL  : '0;
          default: accRdata[t*DATA_W +: DATA_W] <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipiUnit.sv
module ipiUnit
  import ipiPkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NCPU-1:0]        accReq,
  input  logic [NCPU-1:0]        accWe,
  input  logic [NCPU*ADDR_W-1:0] accAddr,
  input  logic [NCPU*DATA_W-1:0] accWdata,
  input  logic [NCPU-1:0]        hwBusy,
  output logic [NCPU-1:0]        accRvalid,
  output logic [NCPU*DATA_W-1:0] accRdata,
  output logic [NCPU-1:0]        ipiIrq
);
  ipiCmdT          cmd [NCPU];
  rdSelT           rdSel [NCPU];
  logic [NCPU-1:0] rdEn;
  logic [NCPU-1:0] pendRemote, pendLocal, mskRemote, mskLocal;

  ipiCtrl #(.NCPU(NCPU)) uCtrl (
    .accReq(accReq), .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata),
    .cmd(cmd), .rdSel(rdSel), .rdEn(rdEn)
  );

  ipiDatapath #(.NCPU(NCPU)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdSel(rdSel), .rdEn(rdEn),
    .hwBusy(hwBusy), .accRvalid(accRvalid), .accRdata(accRdata),
    .ipiIrq(ipiIrq), .pendRemote(pendRemote), .pendLocal(pendLocal),
    .mskRemote(mskRemote), .mskLocal(mskLocal)
  );
endmodule

// File: rtl/ipiUnitChk.sv
module ipiUnitChk
  import ipiPkg::*;
#(
  parameter int NCPU = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NCPU-1:0]        accReq,
  input logic [NCPU-1:0]        accWe,
  input logic [NCPU*ADDR_W-1:0] accAddr,
  input logic [NCPU*DATA_W-1:0] accWdata,
  input logic [NCPU-1:0]        hwBusy,
  input logic [NCPU-1:0]        accRvalid,
  input logic [NCPU*DATA_W-1:0] accRdata,
  input logic [NCPU-1:0]        ipiIrq,
  input logic [NCPU-1:0]        pendRemote,
  input logic [NCPU-1:0]        mskRemote
);
  assert_irq_quiet_R1: assert property (@(posedge clk) !rstN |=> ipiIrq == '0);

  for (genvar p = 0; p < NCPU; p++) begin : gPort
    logic evtRd;
    assign evtRd = accReq[p] && !accWe[p] && accAddr[p*ADDR_W +: ADDR_W] == OFF_EVENT;

    assert_automask_R4: assert property (@(posedge clk) disable iff (!rstN)
      (accRvalid[p] && accRdata[p*DATA_W +: DATA_W] == EVT_REMOTE) |-> mskRemote[p]);

    assert_remote_first_R7: assert property (@(posedge clk) disable iff (!rstN)
      (evtRd && !hwBusy[p] && pendRemote[p] && !mskRemote[p])
      |=> accRdata[p*DATA_W +: DATA_W] == EVT_REMOTE);

    assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rstN)
      (evtRd && hwBusy[p]) |=> (accRvalid[p] && accRdata[p*DATA_W +: DATA_W] == '0));

    assert_send_hits_R3: assert property (@(posedge clk) disable iff (!rstN)
      (accReq[0] && accWe[0] && accAddr[ADDR_W-1:0] == OFF_SEND && accWdata[p])
      |=> pendRemote[p]);
  end
endmodule

bind ipiUnit ipiUnitChk #(.NCPU(NCPU)) uChk (
  .clk(clk), .rstN(rstN), .accReq(accReq), .accWe(accWe), .accAddr(accAddr),
  .accWdata(accWdata), .hwBusy(hwBusy), .accRvalid(accRvalid), .accRdata(accRdata),
  .ipiIrq(ipiIrq), .pendRemote(pendRemote), .mskRemote(mskRemote)
);

// File: tb/ipiUnit_test.sv
`timescale 1ns/1ps
module ipiUnit_test;
  localparam int N = 4;
  localparam logic [31:0] REM = 32'h0004_0001;
  localparam logic [31:0] LOC = 32'h0004_0002;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  accReq = '0, accWe = '0, hwBusy = '0;
  logic [N*16-1:0] accAddr = '0;
  logic [N*32-1:0] accWdata = '0;
  logic [N-1:0]  accRvalid, ipiIrq;
  logic [N*32-1:0] accRdata;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expQ[$];
  int          portQ[$];
  string       tagQ[$];

  ipiUnit #(.NCPU(N)) uut (
    .clk(clk), .rstN(rstN), .accReq(accReq), .accWe(accWe), .accAddr(accAddr),
    .accWdata(accWdata), .hwBusy(hwBusy), .accRvalid(accRvalid),
    .accRdata(accRdata), .ipiIrq(ipiIrq)
  );

  always #4 clk = ~clk;

  task automatic issueWr(input int p, input logic [15:0] a, input logic [31:0] d);
    accReq[p] = 1'b1; accWe[p] = 1'b1;
    accAddr[p*16 +: 16] = a; accWdata[p*32 +: 32] = d;
  endtask

  task automatic issueRd(input int p, input logic [15:0] a, input logic [31:0] e, input string tag);
    accReq[p] = 1'b1; accWe[p] = 1'b0; accAddr[p*16 +: 16] = a;
    expQ.push_back(e); portQ.push_back(p); tagQ.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    accReq = '0; accWe = '0;
  endtask

  task automatic wr(input int p, input logic [15:0] a, input logic [31:0] d);
    issueWr(p, a, d); step();
  endtask

  task automatic rd(input int p, input logic [15:0] a, input logic [31:0] e, input string tag);
    issueRd(p, a, e, tag); step();
  endtask

  task automatic chkIrq(input logic [N-1:0] e, input string tag);
    compared++;
    if (ipiIrq !== e) begin
      mismatched++;
      $display("FAIL %s: ipiIrq actual %b expected %b", tag, ipiIrq, e);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    for (int p = 0; p < N; p++) begin
      if (rstN && accRvalid[p]) begin
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL unexpected read on port %0d: actual %h expected none", p, accRdata[p*32 +: 32]);
        end else begin
          logic [31:0] e; int ep; string tg;
          e = expQ.pop_front(); ep = portQ.pop_front(); tg = tagQ.pop_front();
          if (ep != p || accRdata[p*32 +: 32] !== e) begin
            mismatched++;
            $display("FAIL %s: port %0d data actual %h expected %h (port %0d)",
                     tg, p, accRdata[p*32 +: 32], e, ep);
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkIrq(4'b0000, "R1 reset lines");
    for (int p = 0; p < N; p++) rd(p, 16'h2004, 32'h0, "R1 reset event");
    // R2 identity
    for (int p = 0; p < N; p++) rd(p, 16'h2000, p, "R2 who-am-i");
    // R3 send to a sparse set
    wr(1, 16'h2008, 32'h5);
    chkIrq(4'b0000, "R3 sent but masked");
    wr(0, 16'h2028, 32'h1);
    chkIrq(4'b0001, "R3 cpu0 unmasked");
    wr(2, 16'h2028, 32'h1);
    chkIrq(4'b0101, "R3 cpu2 received, 1 and 3 not");
    // R4 delivery and auto-mask
    rd(0, 16'h2004, REM, "R4 remote code");
    chkIrq(4'b0100, "R4 auto-mask drops line");
    rd(0, 16'h2004, 32'h0, "R4 masked no event");
    // R5 pending retained, ack clears
    wr(0, 16'h2028, 32'h1);
    chkIrq(4'b0101, "R5 unmask re-raises");
    wr(0, 16'h200c, 32'h1);
    chkIrq(4'b0100, "R5 ack clears cpu0");
    wr(2, 16'h200c, 32'h1);
    chkIrq(4'b0000, "R5 ack clears cpu2");
    // R11 middle bits ignored
    wr(1, 16'h2008, 32'h2);
    wr(1, 16'h2028, 32'h7FFF_FFFE);
    chkIrq(4'b0000, "R11 mask-clear middle bits");
    wr(1, 16'h2028, 32'h1);
    chkIrq(4'b0010, "R11 real unmask");
    wr(1, 16'h200c, 32'h7FFF_FFFE);
    chkIrq(4'b0010, "R11 ack middle bits");
    wr(1, 16'h2024, 32'h7FFF_FFFE);
    chkIrq(4'b0010, "R11 mask-set middle bits");
    wr(1, 16'h200c, 32'h1);
    chkIrq(4'b0000, "R11 real ack");
    // R6 local doorbell via view of cpu3
    wr(0, 16'h5188, 32'h8000_0000);
    wr(0, 16'h51a8, 32'h8000_0000);
    chkIrq(4'b1000, "R6 local raised");
    rd(3, 16'h2004, LOC, "R6 local code");
    chkIrq(4'b0000, "R6 local auto-mask");
    // R7 ordering
    wr(0, 16'h5188, 32'h8000_0001);
    wr(0, 16'h51a8, 32'h8000_0001);
    chkIrq(4'b1000, "R7 both ready");
    rd(3, 16'h2004, REM, "R7 remote first");
    rd(3, 16'h2004, LOC, "R7 local second");
    rd(3, 16'h2004, 32'h0, "R7 then none");
    chkIrq(4'b0000, "R7 all masked");
    // R8 hold-off
    wr(0, 16'h51a8, 32'h8000_0001);
    hwBusy[3] = 1'b1;
    rd(3, 16'h2004, 32'h0, "R8 held off");
    chkIrq(4'b1000, "R8 no side effect");
    hwBusy[3] = 1'b0;
    // R9 view clear and mask-set
    wr(2, 16'h518c, 32'h1);
    rd(3, 16'h2004, LOC, "R9 view clear removed remote");
    wr(2, 16'h51a8, 32'h8000_0000);
    chkIrq(4'b1000, "R9 view unmask local");
    wr(2, 16'h51a4, 32'h8000_0000);
    chkIrq(4'b0000, "R9 view mask-set");
    wr(2, 16'h518c, 32'h8000_0000);
    wr(2, 16'h51a8, 32'h8000_0000);
    chkIrq(4'b0000, "R9 view clear local");
    // R10 same-cycle send and ack
    issueWr(0, 16'h2008, 32'h4);
    issueWr(2, 16'h200c, 32'h1);
    step();
    chkIrq(4'b0100, "R10 send wins");
    wr(2, 16'h200c, 32'h1);
    chkIrq(4'b0000, "R10 later ack clears");
    repeat (2) @(negedge clk);
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R2 reads outstanding: actual %0d expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule